// File: doc/BRIEF.md
# Block-Erase Flash Array Model

A synchronous behavioural model of a floating-gate flash array. The array is split into equal erase blocks. A single byte-wide access port reaches both the array and three small control registers. Reads of the array behave like ordinary synchronous memory. A byte write to the array is a program operation. It can only clear bits: the stored byte becomes the AND of the old byte and the new one, and it lands after a short, fixed number of cycles. To return bits to 1, software selects a block in the block-select register and writes the erase code to the command register. After a long, parameterised interval every byte of that block reads 0xFF.

At most one operation is in flight at a time. A `busy` output mirrors the status busy bit. A program or erase requested while busy is dropped and sets a sticky error bit. Each block counts its completed erases. Once the count reaches the endurance limit, the block is marked worn and every further erase of it is refused.

Block size, block count, program time, erase time and endurance limit are parameters. They are scaled down so that simulation stays short.

Top module: `flash_model`

## Requirements
- R1: After reset `busy` is 0, every array byte reads 0xFF, and the status and block-select registers read 0x00.
- R2: A read access (`acc_en`=1, `acc_wr`=0) returns its byte on `acc_rdata` in the cycle after the access edge. `acc_reg`=0 selects the array and `acc_reg`=1 selects a register. The data holds until the next read.
- R3: An array write accepted while idle raises `busy` in the cycle after the access edge. `busy` then stays high for exactly PROG_CYCLES cycles. The new contents are readable once `busy` has fallen, and the done bit is then set.
- R4: A program stores the old byte AND the written byte, so a bit that is 0 never returns to 1 through a write.
- R5: Writing 0xE5 to the command register (register address 1) starts an erase of the block held in the block-select register (register address 0). `busy` stays high for exactly ERASE_CYCLES cycles, and then all bytes of that block read 0xFF.
- R6: An array write or an erase command issued while busy is not carried out and sets the error bit.
- R7: The status register (register address 2) holds busy in bit 0, done in bit 1, error in bit 2 and the worn flag of the selected block in bit 3. Starting an operation clears done. Writing 0xC1 to the command register clears done and error. Any other command value has no effect.
- R8: Each block counts its completed erases. After ERASE_LIMIT of them the block's worn flag is set. A later erase of that block sets the error bit, never raises `busy`, and leaves the block's contents unchanged.
- R9: Array address bits above the in-block offset select the block. An erase touches only the selected block, and the block-select register reads back the index written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access strobe, one access per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_reg | input | 1 | 1 = control register space, 0 = array |
| acc_addr | input | ADDR_W (6) | Array byte address; low 2 bits pick the register |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, registered |
| busy | output | 1 | A program or erase is in progress |

## Verification
Read data is due one cycle after the access edge. The bench drives inputs on falling edges. Its scoreboard pops the expected byte on the falling edge that follows the sampling edge. A program or erase raises `busy` at the access edge itself, so the bench starts counting on the falling edge right after that edge. It counts falling edges until `busy` drops, and requires the count to equal PROG_CYCLES or ERASE_CYCLES. Refused requests are checked on that same first falling edge, where `busy` must still be low. The array contents are checked afterwards through ordinary reads.

// File: rtl/flash_pkg.sv
package flash_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2
    } flash_op_e;

    // register space, decoded from the two low address bits
    localparam logic [1:0] REG_BLKSEL = 2'd0;
    localparam logic [1:0] REG_CMD    = 2'd1;
    localparam logic [1:0] REG_STATUS = 2'd2;

    localparam logic [7:0] CMD_ERASE  = 8'hE5;
    localparam logic [7:0] CMD_CLEAR  = 8'hC1;

    // status bit positions
    localparam int ST_BUSY = 0;
    localparam int ST_DONE = 1;
    localparam int ST_ERR  = 2;
    localparam int ST_WORN = 3;

endpackage

// File: rtl/flash_store.sv
module flash_store #(
    parameter int NUM_BLOCKS  = 4,
    parameter int BLOCK_BYTES = 16,
    localparam int BLK_W  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
    localparam int OFF_W  = (BLOCK_BYTES > 1) ? $clog2(BLOCK_BYTES) : 1,
    localparam int ADDR_W = BLK_W + OFF_W,
    localparam int DEPTH  = NUM_BLOCKS * BLOCK_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_byte,
    input  logic              commit_prog,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [7:0]        prog_data,
    input  logic              commit_erase,
    input  logic [BLK_W-1:0]  erase_blk
);

    logic [DEPTH-1:0][7:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (commit_prog) begin
            mem_d[prog_addr] = mem_q[prog_addr] & prog_data;
        end
        if (commit_erase) begin
            for (int o = 0; o < BLOCK_BYTES; o++) begin
                mem_d[{erase_blk, OFF_W'(o)}] = 8'hFF;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '1;
        else        mem_q <= mem_d;
    end

    assign rd_byte = mem_q[rd_addr];

    for (genvar i = 0; i < DEPTH; i++) begin : g_byte_chk
        localparam int BI = i / BLOCK_BYTES;
        // R4: outside an erase no stored bit ever rises
        a_r4_no_bit_rise: assert property (@(posedge clk) disable iff (!rst_n)
            !commit_erase |=> ((mem_q[i] & ~$past(mem_q[i])) == 8'h00));
        // R5: an erase commit leaves every byte of its block at 0xFF
        a_r5_erase_fills: assert property (@(posedge clk) disable iff (!rst_n)
            (commit_erase && erase_blk == BLK_W'(BI)) |=> (mem_q[i] == 8'hFF));
    end

endmodule

// File: rtl/flash_wear.sv
module flash_wear #(
    parameter int NUM_BLOCKS   = 4,
    parameter int ERASE_LIMIT  = 3,
    localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
    localparam int LIM_W = $clog2(ERASE_LIMIT + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bump,
    input  logic [BLK_W-1:0]      bump_blk,
    output logic [NUM_BLOCKS-1:0] worn
);

    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
        logic [LIM_W-1:0] count_d, count_q;

        always_comb begin
            count_d = count_q;
            if (bump && bump_blk == BLK_W'(g) && count_q != LIM_W'(ERASE_LIMIT)) begin
                count_d = count_q + LIM_W'(1);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) count_q <= '0;
            else        count_q <= count_d;
        end

        assign worn[g] = (count_q == LIM_W'(ERASE_LIMIT));

        // R8: a worn block stays worn
        a_r8_worn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            worn[g] |=> worn[g]);
        // R8: the controller never completes an erase of a worn block
        a_r8_no_worn_commit: assert property (@(posedge clk) disable iff (!rst_n)
            worn[g] |-> !(bump && bump_blk == BLK_W'(g)));
    end

endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl
    import flash_pkg::*;
#(
    parameter int NUM_BLOCKS   = 4,
    parameter int BLOCK_BYTES  = 16,
    parameter int PROG_CYCLES  = 5,
    parameter int ERASE_CYCLES = 300,
    localparam int BLK_W  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
    localparam int OFF_W  = (BLOCK_BYTES > 1) ? $clog2(BLOCK_BYTES) : 1,
    localparam int ADDR_W = BLK_W + OFF_W,
    localparam int MAXC   = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES,
    localparam int CNT_W  = $clog2(MAXC) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_en,
    input  logic                  acc_wr,
    input  logic                  acc_reg,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic [7:0]            acc_wdata,
    output logic [7:0]            acc_rdata,
    output logic                  busy,
    input  logic [7:0]            arr_byte,
    input  logic [NUM_BLOCKS-1:0] worn,
    output logic                  commit_prog,
    output logic [ADDR_W-1:0]     prog_addr,
    output logic [7:0]            prog_data,
    output logic                  commit_erase,
    output logic [BLK_W-1:0]      erase_blk
);

    typedef struct packed {
        flash_op_e         op;
        logic [CNT_W-1:0]  cnt;
        logic [BLK_W-1:0]  sel;
        logic [BLK_W-1:0]  eblk;
        logic [ADDR_W-1:0] paddr;
        logic [7:0]        pdata;
        logic              done;
        logic              err;
        logic [7:0]        rdata;
    } ctrl_state_t;

    ctrl_state_t s_d, s_q;
    logic [7:0]  reg_val;
    logic [1:0]  reg_idx;
    logic        wr_arr, wr_cmd, wr_sel;

    assign reg_idx = acc_addr[1:0];
    assign wr_arr  = acc_en && acc_wr && !acc_reg;
    assign wr_cmd  = acc_en && acc_wr && acc_reg && (reg_idx == REG_CMD);
    assign wr_sel  = acc_en && acc_wr && acc_reg && (reg_idx == REG_BLKSEL);

    assign busy         = (s_q.op != OP_IDLE);
    assign commit_prog  = (s_q.op == OP_PROG)  && (s_q.cnt == '0);
    assign commit_erase = (s_q.op == OP_ERASE) && (s_q.cnt == '0);
    assign prog_addr    = s_q.paddr;
    assign prog_data    = s_q.pdata;
    assign erase_blk    = s_q.eblk;
    assign acc_rdata    = s_q.rdata;

    always_comb begin
        reg_val = 8'h00;
        case (reg_idx)
            REG_BLKSEL: reg_val = 8'(s_q.sel);
            REG_STATUS: begin
                reg_val[ST_BUSY] = busy;
                reg_val[ST_DONE] = s_q.done;
                reg_val[ST_ERR]  = s_q.err;
                reg_val[ST_WORN] = worn[s_q.sel];
            end
            default:    reg_val = 8'h00;
        endcase
    end

    always_comb begin
        s_d = s_q;

        // timer of the operation in flight
        if (busy) begin
            if (s_q.cnt == '0) begin
                s_d.op   = OP_IDLE;
                s_d.done = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end
        end

        // read path
        if (acc_en && !acc_wr) begin
            s_d.rdata = acc_reg ? reg_val : arr_byte;
        end

        // write path
        if (wr_arr) begin
            if (busy) begin
                s_d.err = 1'b1;
            end else begin
                s_d.op    = OP_PROG;
                s_d.cnt   = CNT_W'(PROG_CYCLES - 1);
                s_d.paddr = acc_addr;
                s_d.pdata = acc_wdata;
                s_d.done  = 1'b0;
            end
        end

        if (wr_sel) begin
            s_d.sel = acc_wdata[BLK_W-1:0];
        end

        if (wr_cmd) begin
            if (acc_wdata == CMD_ERASE) begin
                if (busy || worn[s_q.sel]) begin
                    s_d.err = 1'b1;
                end else begin
                    s_d.op   = OP_ERASE;
                    s_d.cnt  = CNT_W'(ERASE_CYCLES - 1);
                    s_d.eblk = s_q.sel;
                    s_d.done = 1'b0;
                end
            end else if (acc_wdata == CMD_CLEAR) begin
                s_d.done = 1'b0;
                s_d.err  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.op    <= OP_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    // R6: a program request while busy is dropped with an error
    a_r6_prog_busy_err: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_arr) |=> s_q.err);
    // R6: an erase request while busy is dropped with an error
    a_r6_erase_busy_err: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_cmd && acc_wdata == CMD_ERASE) |=> s_q.err);
    // R3: an accepted program raises busy on the next cycle
    a_r3_prog_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_arr) |=> (busy && !s_q.done));
    // R8: an erase of a worn block never starts
    a_r8_worn_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_cmd && acc_wdata == CMD_ERASE && worn[s_q.sel]) |=> (!busy && s_q.err));
    // R7: the clear command drops done and error when idle
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_cmd && acc_wdata == CMD_CLEAR) |=> (!s_q.done && !s_q.err));
    // R3: at most one commit per cycle
    a_r3_one_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit_prog, commit_erase}));

endmodule

// File: rtl/flash_model.sv
module flash_model #(
    parameter int NUM_BLOCKS   = 4,
    parameter int BLOCK_BYTES  = 16,
    parameter int PROG_CYCLES  = 5,
    parameter int ERASE_CYCLES = 300,
    parameter int ERASE_LIMIT  = 3,
    localparam int BLK_W  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
    localparam int OFF_W  = (BLOCK_BYTES > 1) ? $clog2(BLOCK_BYTES) : 1,
    localparam int ADDR_W = BLK_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic              acc_reg,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [7:0]        acc_wdata,
    output logic [7:0]        acc_rdata,
    output logic              busy
);

    logic [7:0]            arr_byte;
    logic [NUM_BLOCKS-1:0] worn;
    logic                  commit_prog, commit_erase;
    logic [ADDR_W-1:0]     prog_addr;
    logic [7:0]            prog_data;
    logic [BLK_W-1:0]      erase_blk;

    flash_ctrl #(
        .NUM_BLOCKS  (NUM_BLOCKS),
        .BLOCK_BYTES (BLOCK_BYTES),
        .PROG_CYCLES (PROG_CYCLES),
        .ERASE_CYCLES(ERASE_CYCLES)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_en      (acc_en),
        .acc_wr      (acc_wr),
        .acc_reg     (acc_reg),
        .acc_addr    (acc_addr),
        .acc_wdata   (acc_wdata),
        .acc_rdata   (acc_rdata),
        .busy        (busy),
        .arr_byte    (arr_byte),
        .worn        (worn),
        .commit_prog (commit_prog),
        .prog_addr   (prog_addr),
        .prog_data   (prog_data),
        .commit_erase(commit_erase),
        .erase_blk   (erase_blk)
    );

    flash_store #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .BLOCK_BYTES(BLOCK_BYTES)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_addr     (acc_addr),
        .rd_byte     (arr_byte),
        .commit_prog (commit_prog),
        .prog_addr   (prog_addr),
        .prog_data   (prog_data),
        .commit_erase(commit_erase),
        .erase_blk   (erase_blk)
    );

    flash_wear #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .ERASE_LIMIT(ERASE_LIMIT)
    ) u_wear (
        .clk     (clk),
        .rst_n   (rst_n),
        .bump    (commit_erase),
        .bump_blk(erase_blk),
        .worn    (worn)
    );

endmodule

// File: tb/flash_model_bench.sv
`timescale 1ns/1ps
module flash_model_bench;

    localparam int PROG_N  = 5;
    localparam int ERASE_N = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_en = 1'b0;
    logic       acc_wr = 1'b0;
    logic       acc_reg = 1'b0;
    logic [5:0] acc_addr = '0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] acc_rdata;
    logic       busy;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       rd_pending = 1'b0;

    always #4 clk = ~clk;

    flash_model u_flash_model (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_en   (acc_en),
        .acc_wr   (acc_wr),
        .acc_reg  (acc_reg),
        .acc_addr (acc_addr),
        .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata),
        .busy     (busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // monitor: compare read data on the falling edge after the access edge
    always @(posedge clk) rd_pending <= rst_n && acc_en && !acc_wr;

    always @(negedge clk) begin
        if (rd_pending) begin
            if (exp_q.size() == 0) begin
                chk("scoreboard underflow", 1, 0);
            end else begin
                chk(tag_q.pop_front(), int'(acc_rdata), int'(exp_q.pop_front()));
            end
        end
    end

    task automatic access(input logic wr, input logic rg, input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = wr; acc_reg = rg; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0;
    endtask

    task automatic rd(input logic rg, input logic [5:0] a, input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        access(1'b0, rg, a, 8'h00);
    endtask

    task automatic wr_arr(input logic [5:0] a, input logic [7:0] d);
        access(1'b1, 1'b0, a, d);
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [7:0] d);
        access(1'b1, 1'b1, a, d);
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R1 busy after reset", int'(busy), 0);
        rd(1'b1, 6'd2, 8'h00, "R1 status after reset");
        rd(1'b0, 6'd0, 8'hFF, "R1 first byte erased");
        rd(1'b0, 6'd63, 8'hFF, "R1 last byte erased");
        rd(1'b1, 6'd0, 8'h00, "R9 block select after reset");

        // program and its length
        wr_arr(6'd5, 8'hA5);
        count_busy(n);
        chk("R3 program busy cycles", n, PROG_N);
        rd(1'b0, 6'd5, 8'hA5, "R2 R3 programmed byte");
        rd(1'b1, 6'd2, 8'h02, "R7 done after program");

        // AND-only programming
        wr_arr(6'd5, 8'h3C);
        count_busy(n);
        rd(1'b0, 6'd5, 8'h24, "R4 program ANDs");
        wr_arr(6'd5, 8'hFF);
        count_busy(n);
        rd(1'b0, 6'd5, 8'h24, "R4 no bit returns to one");

        // rejection while programming
        wr_arr(6'd19, 8'h11);
        wr_arr(6'd7, 8'h00);
        count_busy(n);
        rd(1'b0, 6'd7, 8'hFF, "R6 write while busy dropped");
        rd(1'b0, 6'd19, 8'h11, "R3 second program");
        rd(1'b1, 6'd2, 8'h06, "R6 error bit set");
        wr_reg(6'd1, 8'hC1);
        rd(1'b1, 6'd2, 8'h00, "R7 clear command");
        wr_reg(6'd1, 8'h77);
        chk("R7 unknown command no busy", int'(busy), 0);
        rd(1'b1, 6'd2, 8'h00, "R7 unknown command ignored");

        // erase of block 0
        wr_reg(6'd0, 8'h00);
        rd(1'b1, 6'd0, 8'h00, "R9 block select readback 0");
        wr_reg(6'd1, 8'hE5);
        count_busy(n);
        chk("R5 erase busy cycles", n, ERASE_N);
        rd(1'b0, 6'd5, 8'hFF, "R5 erased byte");
        rd(1'b0, 6'd19, 8'h11, "R9 other block untouched");
        rd(1'b1, 6'd2, 8'h02, "R5 done after erase");

        // erase of block 3 with requests during it
        wr_reg(6'd0, 8'h03);
        rd(1'b1, 6'd0, 8'h03, "R9 block select readback 3");
        wr_arr(6'd48, 8'h0F);
        count_busy(n);
        wr_reg(6'd1, 8'hE5);
        rd(1'b1, 6'd2, 8'h01, "R7 busy bit during erase");
        wr_arr(6'd49, 8'h00);
        wr_reg(6'd1, 8'hE5);
        count_busy(n);
        rd(1'b0, 6'd48, 8'hFF, "R5 block 3 erased");
        rd(1'b0, 6'd49, 8'hFF, "R6 program during erase dropped");
        rd(1'b1, 6'd2, 8'h06, "R6 error after busy requests");
        wr_reg(6'd1, 8'hC1);

        // endurance on block 2
        wr_reg(6'd0, 8'h02);
        wr_arr(6'd33, 8'h00);
        count_busy(n);
        for (int k = 0; k < 3; k++) begin
            wr_reg(6'd1, 8'hE5);
            count_busy(n);
            chk("R8 erase within limit runs", n, ERASE_N);
        end
        rd(1'b1, 6'd2, 8'h0A, "R8 worn after limit");
        wr_arr(6'd33, 8'h55);
        count_busy(n);
        rd(1'b0, 6'd33, 8'h55, "R8 worn block still programmable");
        wr_reg(6'd1, 8'hC1);
        wr_reg(6'd1, 8'hE5);
        chk("R8 worn erase no busy", int'(busy), 0);
        rd(1'b1, 6'd2, 8'h0C, "R8 worn erase error");
        rd(1'b0, 6'd33, 8'h55, "R8 worn block unchanged");
        wr_reg(6'd0, 8'h03);
        rd(1'b1, 6'd2, 8'h04, "R8 other block not worn");

        repeat (3) @(negedge clk);
        chk("scoreboard drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule